// File: doc/BRIEF.md
# Carry-Aware Add, Reverse-Subtract and Compare Unit

This block is the integer add path of a 32-bit processor datapath. It is purely combinational. Each cycle it takes a 6-bit major opcode, a small function field, operand A, a register operand, an immediate and the current carry flag. It returns one result word, plus a carry-write enable and the next carry value. The register file and the status register that holds the carry live outside the block. The carry is only an input and an output here.

Subtraction is reversed: it computes B minus A. Three opcode bits control the arithmetic group:
- one bit chooses between add and reverse-subtract;
- one bit chooses whether the incoming carry flag replaces the constant carry-in;
- one bit chooses whether the carry-out is written back.

A fourth opcode bit swaps the register operand for the immediate. Compares do not return a flag. They return the B minus A difference with its top bit patched, so that the sign of the result gives the ordering, signed or unsigned.

A separate unary group covers three single-bit right shifts and two sign extensions. The shifts move bit 0 into the carry, and each fills bit 31 in its own way.

Top module: `carry_alu`

## Requirements
- R1: Opcodes 0x00 (add) and 0x02 (add with carry) return A+B+cin, where cin is 0 for 0x00 and carry_i for 0x02. carry_we_o is 1 and carry_o is bit 32 of the 33-bit sum.
- R2: Opcodes 0x01 and 0x03 (reverse subtract) return B+~A+cin, where cin is 1 for 0x01 and carry_i for 0x03. carry_we_o is 1 and carry_o is bit 32 of that sum. Opcode bit 0 selects reversal and opcode bit 1 selects the carry-flag carry-in.
- R3: When opcode bit 2 is set in the group 0x00 to 0x0F, the result is the same sum, but carry_we_o is 0 and carry_o equals carry_i.
- R4: When opcode bit 3 is set in the group 0x00 to 0x0F, imm_i is used as B and b_reg_i has no effect on any output.
- R5: Opcode 0x05 with func_i[1:0]=01 is a signed compare. It returns B+~A+1, and when the top bits of A and B differ, the result's bit 31 is replaced by B's bit 31. It does not write the carry.
- R6: Opcode 0x05 with func_i[1:0]=11 is an unsigned compare. It returns the same difference, and when the top bits differ, bit 31 is replaced by A's bit 31. With func_i[1:0] equal to 00 or 10 the opcode is a plain reverse subtract without carry write. In every other arithmetic opcode, including 0x0D, func_i has no effect.
- R7: Opcode 0x24 with func_i=0 (arithmetic), 1 (through carry) or 2 (logical) returns A shifted right by one bit. Bit 31 is filled with A's bit 31, with carry_i, or with 0 respectively. carry_we_o is 1 and carry_o is A's bit 0.
- R8: Opcode 0x24 with func_i=4 replicates A's bit 7 into bits 31:8, and with func_i=5 it replicates A's bit 15 into bits 31:16. Neither writes the carry.
- R9: An opcode outside 0x00 to 0x0F and other than 0x24, or opcode 0x24 with an unassigned func_i, returns 0 with carry_we_o at 0.
- R10: Whenever carry_we_o is 0, carry_o equals carry_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Major opcode |
| func_i | input | FUNC_W (4) | Function field for opcodes 0x05 and 0x24 |
| a_i | input | DATA_W (32) | Operand A |
| b_reg_i | input | DATA_W (32) | Register operand, used as B when opcode bit 3 is 0 |
| imm_i | input | DATA_W (32) | Immediate already extended to full width, used as B when opcode bit 3 is 1 |
| carry_i | input | 1 | Current carry flag |
| result_o | output | DATA_W (32) | Result word |
| carry_we_o | output | 1 | Carry write enable |
| carry_o | output | 1 | Next carry value; equals carry_i when not written |

## Verification
Every output is combinational, so each result, carry-write enable and carry value is due in the same cycle as the inputs that produce it. No register lies between the inputs and the outputs. The bench applies each stimulus just after a falling clock edge and samples the outputs a quarter period later, well before the next rising edge. Because of this, no check depends on the order of events at a clock edge. The reset check holds all inputs at zero during reset and reads the resulting add of zeros.

// File: rtl/carry_alu_pkg.sv
package carry_alu_pkg;
  localparam logic [5:0] OP_CMP_GRP = 6'h05;
  localparam logic [5:0] OP_UNARY   = 6'h24;

  typedef enum logic [2:0] {
    UN_SRA    = 3'd0,
    UN_SRC    = 3'd1,
    UN_SRL    = 3'd2,
    UN_SEXT8  = 3'd4,
    UN_SEXT16 = 3'd5
  } unary_fn_e;

  typedef struct packed {
    logic arith;
    logic use_imm;
    logic keep;
    logic use_cin;
    logic rev;
    logic cmp;
    logic cmp_uns;
    logic unary;
  } alu_dec_t;
endpackage

// File: rtl/carry_alu_decode.sv
module carry_alu_decode
  import carry_alu_pkg::*;
#(
  parameter int FUNC_W = 4
) (
  input  logic [5:0]        op_i,
  input  logic [FUNC_W-1:0] func_i,
  output alu_dec_t          dec_o
);
  always_comb begin
    dec_o         = '0;
    dec_o.arith   = (op_i[5:4] == 2'b00);
    dec_o.use_imm = op_i[3];
    dec_o.keep    = op_i[2];
    dec_o.use_cin = op_i[1];
    dec_o.rev     = op_i[0];
    dec_o.unary   = (op_i == OP_UNARY);
    // compare exists only in the register form of the keep reverse-subtract
    dec_o.cmp     = (op_i == OP_CMP_GRP) && func_i[0];
    dec_o.cmp_uns = (op_i == OP_CMP_GRP) && func_i[0] && func_i[1];
  end

  always_comb begin
    if (dec_o.cmp) assert (dec_o.arith && dec_o.keep && dec_o.rev && !dec_o.use_imm)
      else $error("a_r6_cmp_in_keep_rsub");
    if (dec_o.unary) assert (!dec_o.arith) else $error("a_r9_groups_disjoint");
  end
endmodule

// File: rtl/carry_alu_addsub.sv
module carry_alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              rev_i,
  input  logic              use_cin_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o
);
  localparam int SUM_W = DATA_W + 1;

  logic [DATA_W-1:0] x;
  logic              cin;
  logic [SUM_W-1:0]  sum_ext;

  always_comb begin
    x       = rev_i ? ~a_i : a_i;
    cin     = use_cin_i ? carry_i : rev_i;
    sum_ext = {1'b0, x} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin};
    sum_o   = sum_ext[DATA_W-1:0];
    cout_o  = sum_ext[DATA_W];
  end
endmodule

// File: rtl/carry_alu_unary.sv
module carry_alu_unary
  import carry_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FUNC_W = 4
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              we_o,
  output logic              cout_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] shr;

  always_comb begin
    shr    = {1'b0, a_i[MSB:1]};
    res_o  = '0;
    we_o   = 1'b0;
    cout_o = carry_i;
    if (func_i[FUNC_W-1:3] == '0) begin
      unique case (unary_fn_e'(func_i[2:0]))
        UN_SRA:    begin res_o = shr | {a_i[MSB], {MSB{1'b0}}}; we_o = 1'b1; cout_o = a_i[0]; end
        UN_SRC:    begin res_o = shr | {carry_i, {MSB{1'b0}}};  we_o = 1'b1; cout_o = a_i[0]; end
        UN_SRL:    begin res_o = shr;                           we_o = 1'b1; cout_o = a_i[0]; end
        UN_SEXT8:  res_o = {{(DATA_W-8){a_i[7]}}, a_i[7:0]};
        UN_SEXT16: res_o = {{(DATA_W-16){a_i[15]}}, a_i[15:0]};
        default:   res_o = '0;
      endcase
    end
  end

  always_comb begin
    if (func_i == FUNC_W'(UN_SEXT8))
      assert (res_o[MSB:8] == {(DATA_W-8){a_i[7]}} && !we_o) else $error("a_r8_sext8");
    if (func_i == FUNC_W'(UN_SEXT16))
      assert (res_o[MSB:16] == {(DATA_W-16){a_i[15]}} && !we_o) else $error("a_r8_sext16");
    if (we_o) assert (res_o[MSB-1:0] == a_i[MSB:1]) else $error("a_r7_shift_body");
  end
endmodule

// File: rtl/carry_alu.sv
module carry_alu
  import carry_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FUNC_W = 4
) (
  input  logic [5:0]        op_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_reg_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_we_o,
  output logic              carry_o
);
  localparam int MSB = DATA_W - 1;

  alu_dec_t          dec;
  logic [DATA_W-1:0] b_sel;
  logic [DATA_W-1:0] sum;
  logic              sum_cout;
  logic [DATA_W-1:0] un_res;
  logic              un_we;
  logic              un_cout;
  logic [DATA_W-1:0] arith_res;

  carry_alu_decode #(.FUNC_W(FUNC_W)) i_decode (
    .op_i   (op_i),
    .func_i (func_i),
    .dec_o  (dec)
  );

  assign b_sel = dec.use_imm ? imm_i : b_reg_i;

  carry_alu_addsub #(.DATA_W(DATA_W)) i_addsub (
    .a_i       (a_i),
    .b_i       (b_sel),
    .rev_i     (dec.rev),
    .use_cin_i (dec.use_cin),
    .carry_i   (carry_i),
    .sum_o     (sum),
    .cout_o    (sum_cout)
  );

  carry_alu_unary #(.DATA_W(DATA_W), .FUNC_W(FUNC_W)) i_unary (
    .a_i     (a_i),
    .func_i  (func_i),
    .carry_i (carry_i),
    .res_o   (un_res),
    .we_o    (un_we),
    .cout_o  (un_cout)
  );

  // compare: on sign mismatch the top bit shows the ordering instead of the wrapped difference
  always_comb begin
    arith_res = sum;
    if (dec.cmp && (a_i[MSB] ^ b_sel[MSB]))
      arith_res[MSB] = dec.cmp_uns ? a_i[MSB] : b_sel[MSB];
  end

  always_comb begin
    result_o   = '0;
    carry_we_o = 1'b0;
    carry_o    = carry_i;
    if (dec.arith) begin
      result_o   = arith_res;
      carry_we_o = !dec.keep;
      carry_o    = dec.keep ? carry_i : sum_cout;
    end else if (dec.unary) begin
      result_o   = un_res;
      carry_we_o = un_we;
      carry_o    = un_cout;
    end
  end

  always_comb begin
    if (op_i[5:4] == 2'b00 && op_i[2]) assert (!carry_we_o) else $error("a_r3_keep_no_write");
    if (!carry_we_o) assert (carry_o == carry_i) else $error("a_r10_carry_hold");
    if (dec.cmp && (a_i[MSB] ^ b_reg_i[MSB]) && !dec.cmp_uns)
      assert (result_o[MSB] == b_reg_i[MSB]) else $error("a_r5_signed_msb");
    if (dec.cmp_uns && (a_i[MSB] ^ b_reg_i[MSB]))
      assert (result_o[MSB] == a_i[MSB]) else $error("a_r6_unsigned_msb");
    if (op_i == OP_UNARY && carry_we_o) assert (carry_o == a_i[0]) else $error("a_r7_shift_carry");
    if (op_i[5:4] != 2'b00 && op_i != OP_UNARY)
      assert (result_o == '0 && !carry_we_o) else $error("a_r9_unused_op");
  end
endmodule

// File: tb/test_carry_alu.sv
module test_carry_alu;
  localparam int DATA_W = 32;
  localparam int FUNC_W = 4;
  localparam int NVEC   = 24;

  typedef struct packed {
    logic [5:0]  op;
    logic [3:0]  fn;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] imm;
    logic        cin;
    logic [31:0] res;
    logic        we;
    logic        co;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{6'h00, 4'h0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0, 1'b0, 32'h0000_0000, 1'b1, 1'b1}, // R1 add wraps
    '{6'h02, 4'h0, 32'h0000_0001, 32'h0000_0002, 32'h0, 1'b1, 32'h0000_0004, 1'b1, 1'b0}, // R1 addc
    '{6'h01, 4'h0, 32'h0000_0005, 32'h0000_0003, 32'h0, 1'b0, 32'hFFFF_FFFE, 1'b1, 1'b0}, // R2 rsub borrow
    '{6'h01, 4'h0, 32'h0000_0003, 32'h0000_0005, 32'h0, 1'b0, 32'h0000_0002, 1'b1, 1'b1}, // R2 rsub
    '{6'h03, 4'h0, 32'h0000_0001, 32'h0000_0005, 32'h0, 1'b0, 32'h0000_0003, 1'b1, 1'b1}, // R2 rsubc
    '{6'h04, 4'h0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0, 1'b0, 32'h0000_0000, 1'b0, 1'b0}, // R3 addk
    '{6'h06, 4'h0, 32'h0000_0010, 32'h0000_0020, 32'h0, 1'b1, 32'h0000_0031, 1'b0, 1'b1}, // R3 addkc
    '{6'h07, 4'h0, 32'h0000_0000, 32'h0000_0000, 32'h0, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0}, // R3 rsubkc
    '{6'h08, 4'h0, 32'h0000_0100, 32'h0000_DEAD, 32'h23, 1'b0, 32'h0000_0123, 1'b1, 1'b0}, // R4 addi
    '{6'h09, 4'h0, 32'h0000_0001, 32'h0000_0055, 32'h0, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0}, // R4 rsubi
    '{6'h0E, 4'h0, 32'h0000_0000, 32'h1234_5678, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 1'b0, 1'b1}, // R4 addikc
    '{6'h05, 4'h0, 32'h0000_0002, 32'h0000_0007, 32'h0, 1'b0, 32'h0000_0005, 1'b0, 1'b0}, // R6 rsubk
    '{6'h05, 4'h1, 32'h0000_0001, 32'h8000_0000, 32'h0, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0}, // R5 cmp mixed
    '{6'h05, 4'h1, 32'h0000_0005, 32'h0000_0003, 32'h0, 1'b1, 32'hFFFF_FFFE, 1'b0, 1'b1}, // R5 cmp same sign
    '{6'h05, 4'h3, 32'h0000_0001, 32'h8000_0000, 32'h0, 1'b0, 32'h7FFF_FFFF, 1'b0, 1'b0}, // R6 cmpu
    '{6'h05, 4'h3, 32'h8000_0000, 32'h0000_0001, 32'h0, 1'b0, 32'h8000_0001, 1'b0, 1'b0}, // R6 cmpu
    '{6'h0D, 4'h1, 32'h0000_0001, 32'h0, 32'h8000_0000, 1'b0, 32'h7FFF_FFFF, 1'b0, 1'b0}, // R6 rsubik no patch
    '{6'h24, 4'h0, 32'h8000_0003, 32'h0, 32'h0, 1'b0, 32'hC000_0001, 1'b1, 1'b1}, // R7 sra
    '{6'h24, 4'h1, 32'h0000_0002, 32'h0, 32'h0, 1'b1, 32'h8000_0001, 1'b1, 1'b0}, // R7 src
    '{6'h24, 4'h2, 32'h8000_0001, 32'h0, 32'h0, 1'b0, 32'h4000_0000, 1'b1, 1'b1}, // R7 srl
    '{6'h24, 4'h4, 32'h1234_5680, 32'h0, 32'h0, 1'b1, 32'hFFFF_FF80, 1'b0, 1'b1}, // R8 sext8
    '{6'h24, 4'h5, 32'hABCD_7FFF, 32'h0, 32'h0, 1'b0, 32'h0000_7FFF, 1'b0, 1'b0}, // R8 sext16
    '{6'h10, 4'h0, 32'h0000_0005, 32'h0000_0006, 32'h0, 1'b1, 32'h0000_0000, 1'b0, 1'b1}, // R9 R10 unused op
    '{6'h24, 4'h3, 32'h0000_000F, 32'h0, 32'h0, 1'b0, 32'h0000_0000, 1'b0, 1'b0}  // R9 unassigned unary
  };

  logic              clk;
  logic              rst_n;
  logic [5:0]        op;
  logic [FUNC_W-1:0] fn;
  logic [DATA_W-1:0] a, b, imm;
  logic              cin;
  logic [DATA_W-1:0] res;
  logic              we, co;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  carry_alu #(.DATA_W(DATA_W), .FUNC_W(FUNC_W)) i_carry_alu (
    .op_i       (op),
    .func_i     (fn),
    .a_i        (a),
    .b_reg_i    (b),
    .imm_i      (imm),
    .carry_i    (cin),
    .result_o   (res),
    .carry_we_o (we),
    .carry_o    (co)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got_r, exp_r,
                       input logic got_w, exp_w, got_c, exp_c);
    n_checks++;
    if (got_r !== exp_r || got_w !== exp_w || got_c !== exp_c) begin
      n_fail++;
      $display("FAIL %s: got res=%h we=%b c=%b, expected res=%h we=%b c=%b",
               req, got_r, got_w, got_c, exp_r, exp_w, exp_c);
    end
  endtask

  task automatic apply(input logic [5:0] o, input logic [3:0] f, input logic [31:0] va, vb, vi,
                       input logic c);
    @(negedge clk);
    op = o; fn = f; a = va; b = vb; imm = vi; cin = c;
    #5;
  endtask

  initial begin
    op = '0; fn = '0; a = '0; b = '0; imm = '0; cin = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    check("R1 reset state", res, 32'h0, we, 1'b1, co, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i].op, VECS[i].fn, VECS[i].a, VECS[i].b, VECS[i].imm, VECS[i].cin);
      check($sformatf("table vector %0d", i), res, VECS[i].res, we, VECS[i].we, co, VECS[i].co);
    end

    // R4: register operand has no effect in immediate form
    apply(6'h08, 4'h0, 32'h0000_0100, 32'hFFFF_FFFF, 32'h23, 1'b0);
    check("R4 b_reg ignored", res, 32'h0000_0123, we, 1'b1, co, 1'b0);
    // R6: func field has no effect on plain add
    apply(6'h00, 4'h3, 32'h0000_0001, 32'h0000_0001, 32'h0, 1'b0);
    check("R6 func ignored on add", res, 32'h0000_0002, we, 1'b1, co, 1'b0);
    // R6: func 10 on 0x05 is plain rsubk
    apply(6'h05, 4'h2, 32'h0000_0001, 32'h8000_0000, 32'h0, 1'b1);
    check("R6 func 10 plain rsubk", res, 32'h7FFF_FFFF, we, 1'b0, co, 1'b1);
    // R2: rsubc with carry set behaves as full subtract, equal operands
    apply(6'h03, 4'h0, 32'h1234_5678, 32'h1234_5678, 32'h0, 1'b1);
    check("R2 rsubc equal", res, 32'h0, we, 1'b1, co, 1'b1);
    // R5: signed compare, A negative, B positive -> positive result
    apply(6'h05, 4'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h0, 1'b0);
    check("R5 cmp neg A", res, 32'h0000_0000, we, 1'b0, co, 1'b0);
    // R7: src with carry clear inserts zero
    apply(6'h24, 4'h1, 32'h8000_0000, 32'h0, 32'h0, 1'b0);
    check("R7 src zero fill", res, 32'h4000_0000, we, 1'b1, co, 1'b0);
    // R10: keep variant holds a set carry
    apply(6'h0C, 4'h0, 32'hFFFF_FFFF, 32'h0, 32'h0000_0002, 1'b1);
    check("R10 addik holds carry", res, 32'h0000_0001, we, 1'b0, co, 1'b1);
    // R9: top opcode
    apply(6'h3F, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    check("R9 opcode 0x3F", res, 32'h0, we, 1'b0, co, 1'b0);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule